// File: doc/BRIEF.md
# Bank-Aware DRAM Command Sequencer

This block turns a stream of read and write requests into row and column commands for an eight-bank DDR3-style memory. It issues at most one command per clock. Each bank has its own record of whether a row is open, which row that is, and three down-counters that gate that bank's next activate, column access and precharge. Every precharge is an explicit command; auto-precharge is never used.

Each request arrives with a one-deep lookahead that describes the request queued behind it. A request that hits the open row of its bank goes straight to its column command. A request that finds a different row open first closes that row. A request to a closed bank opens its row and then accesses it. When the lookahead shows that the next request needs a different row in the same bank, the sequencer closes the bank as the last step of the current request, as soon as the write recovery or read-to-precharge window allows. Accesses to different banks leave the other banks open, so random traffic can be spread across banks. All timing values are parameters counted in clock cycles. The data path, refresh, initialization and the PHY are not part of this block.

Top module: `dseq_top`

## Requirements
- R1: In the first cycle after reset the command code is NOP (0), `req_ready` is high, and every bank is closed, so the first request to any bank starts with an ACTIVATE.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the last command of that request has been issued. Only one command is issued per cycle, and NOP is issued in every cycle in which no command is legal.
- R3: ACTIVATE is issued only to a closed bank. A request to a closed bank produces ACTIVATE (with the request row) and then its column command.
- R4: A request whose row equals the open row of its bank produces only its column command: no ACTIVATE and no PRECHARGE.
- R5: A request that finds a different row open in its bank produces PRECHARGE, then ACTIVATE, then its column command. PRECHARGE is issued only to an open bank.
- R6: PRECHARGE and the next ACTIVATE to the same bank are at least T_RP cycles apart.
- R7: ACTIVATE and the next READ or WRITE to the same bank are at least T_RCD cycles apart. On an otherwise idle bank the gap is exactly T_RCD.
- R8: PRECHARGE to a bank comes at least T_WL+T_BURST+T_WR cycles after the last WRITE to that bank and at least T_RTP cycles after the last READ to it. After a WRITE with nothing else pending, the gap is exactly T_WL+T_BURST+T_WR.
- R9: Any two column commands (READ or WRITE, any banks) are at least T_CCD cycles apart.
- R10: If the lookahead is valid and names the same bank with a different row, the current request ends with a PRECHARGE to that bank. Otherwise the bank is left open after the column command.
- R11: Activating one bank does not close any other bank. Rows left open in other banks are still hits later.
- R12: Command codes are NOP=0, ACTIVATE=1, READ=2, WRITE=3, PRECHARGE=4. `cmd_addr` carries the row on ACTIVATE, the column on READ and WRITE, and zero otherwise. `cmd_bank` carries the target bank, or zero on NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 3 | Request bank |
| req_row | input | 14 | Request row |
| req_col | input | 10 | Request column |
| nxt_valid | input | 1 | Lookahead describes a queued request |
| nxt_bank | input | 3 | Bank of the queued request |
| nxt_row | input | 14 | Row of the queued request |
| cmd_code | output | 3 | Issued command (registered) |
| cmd_bank | output | 3 | Bank of the issued command |
| cmd_addr | output | 14 | Row or column of the issued command |

## Verification
The hardest case to reach from the ports is a precharge started by the lookahead that must wait out the long write recovery window, followed at once by a request that must then wait for tRP before it can activate, while a row left open in another bank must still count as a hit. Requests are drawn from a small set of banks and rows so that hits, misses and early closes keep recurring. The lookahead always describes the request that really follows, and it is hidden at random so that both the planned and the unplanned close paths get exercised. Directed cases measure the exact activate-to-write and write-to-precharge gaps.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_CLOSE
  } seq_st_e;
endpackage

// File: rtl/dseq_bank.sv
module dseq_bank #(
  parameter int ROW_W  = 14,
  parameter int CNT_W  = 6,
  parameter int T_RP   = 6,
  parameter int T_RCD  = 6,
  parameter int WR2PRE = 16,
  parameter int T_RTP  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             do_act,
  input  logic             do_pre,
  input  logic             do_rd,
  input  logic             do_wr,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] open_row,
  output logic             act_ok,
  output logic             col_ok,
  output logic             pre_ok
);
  localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] RCD_LD = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] WP_LD  = CNT_W'(WR2PRE - 1);
  localparam logic [CNT_W-1:0] RTP_LD = CNT_W'(T_RTP - 1);

  logic [CNT_W-1:0] rp_c, rcd_c, pre_c;
  logic [CNT_W-1:0] pre_dec;

  assign pre_dec  = (pre_c != '0) ? pre_c - 1'b1 : '0;
  assign act_ok   = (rp_c == '0);
  assign col_ok   = (rcd_c == '0);
  assign pre_ok   = (pre_c == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      is_open  <= 1'b0;
      open_row <= '0;
      rp_c     <= '0;
      rcd_c    <= '0;
      pre_c    <= '0;
    end else begin
      if (rp_c != '0)  rp_c  <= rp_c - 1'b1;
      if (rcd_c != '0) rcd_c <= rcd_c - 1'b1;
      pre_c <= pre_dec;
      if (do_act) begin
        is_open  <= 1'b1;
        open_row <= row_in;
        rcd_c    <= RCD_LD;
      end
      if (do_pre) begin
        is_open <= 1'b0;
        rp_c    <= RP_LD;
      end
      if (do_wr && (WP_LD > pre_dec))  pre_c <= WP_LD;
      if (do_rd && (RTP_LD > pre_dec)) pre_c <= RTP_LD;
    end
  end
endmodule

// File: rtl/dseq_top.sv
module dseq_top
  import dseq_pkg::*;
#(
  parameter int BANKS   = 8,
  parameter int ROW_W   = 14,
  parameter int COL_W   = 10,
  parameter int T_RP    = 6,
  parameter int T_RCD   = 6,
  parameter int T_WL    = 5,
  parameter int T_BURST = 4,
  parameter int T_WR    = 7,
  parameter int T_RTP   = 4,
  parameter int T_CCD   = 4,
  localparam int BANK_W = $clog2(BANKS),
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              nxt_valid,
  input  logic [BANK_W-1:0] nxt_bank,
  input  logic [ROW_W-1:0]  nxt_row,
  output logic [2:0]        cmd_code,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr
);
  localparam int WR2PRE = T_WL + T_BURST + T_WR;
  localparam int CNT_W  = $clog2(WR2PRE + T_RP + T_RCD + T_RTP + T_CCD + 1);

  seq_st_e           state, nx_state;
  cmd_e              nx_cmd;
  logic              cur_write, la_valid;
  logic [BANK_W-1:0] cur_bank, la_bank;
  logic [ROW_W-1:0]  cur_row, la_row;
  logic [COL_W-1:0]  cur_col;
  logic [CNT_W-1:0]  ccd_c;

  logic             bk_open [BANKS];
  logic [ROW_W-1:0] bk_row  [BANKS];
  logic             bk_act_ok [BANKS];
  logic             bk_col_ok [BANKS];
  logic             bk_pre_ok [BANKS];

  generate
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic sel;
      assign sel = (cur_bank == BANK_W'(b));
      dseq_bank #(
        .ROW_W(ROW_W), .CNT_W(CNT_W), .T_RP(T_RP), .T_RCD(T_RCD),
        .WR2PRE(WR2PRE), .T_RTP(T_RTP)
      ) bank_i (
        .clk(clk), .rst(rst),
        .do_act(sel && nx_cmd == CMD_ACT),
        .do_pre(sel && nx_cmd == CMD_PRE),
        .do_rd (sel && nx_cmd == CMD_RD),
        .do_wr (sel && nx_cmd == CMD_WR),
        .row_in(cur_row),
        .is_open(bk_open[b]), .open_row(bk_row[b]),
        .act_ok(bk_act_ok[b]), .col_ok(bk_col_ok[b]), .pre_ok(bk_pre_ok[b])
      );
    end
  endgenerate

  always_comb begin
    nx_cmd   = CMD_NOP;
    nx_state = state;
    case (state)
      ST_IDLE: if (req_valid) nx_state = ST_RUN;
      ST_RUN: begin
        if (!bk_open[cur_bank]) begin
          if (bk_act_ok[cur_bank]) nx_cmd = CMD_ACT;
        end else if (bk_row[cur_bank] != cur_row) begin
          if (bk_pre_ok[cur_bank]) nx_cmd = CMD_PRE;
        end else if (bk_col_ok[cur_bank] && ccd_c == '0) begin
          nx_cmd   = cur_write ? CMD_WR : CMD_RD;
          nx_state = (la_valid && la_bank == cur_bank && la_row != cur_row)
                     ? ST_CLOSE : ST_IDLE;
        end
      end
      ST_CLOSE: if (bk_pre_ok[cur_bank]) begin
        nx_cmd   = CMD_PRE;
        nx_state = ST_IDLE;
      end
      default: nx_state = ST_IDLE;
    endcase
  end

  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cur_write <= 1'b0;
      cur_bank  <= '0;
      cur_row   <= '0;
      cur_col   <= '0;
      la_valid  <= 1'b0;
      la_bank   <= '0;
      la_row    <= '0;
      ccd_c     <= '0;
      cmd_code  <= CMD_NOP;
      cmd_bank  <= '0;
      cmd_addr  <= '0;
    end else begin
      state <= nx_state;
      if (state == ST_IDLE && req_valid) begin
        cur_write <= req_write;
        cur_bank  <= req_bank;
        cur_row   <= req_row;
        cur_col   <= req_col;
        la_valid  <= nxt_valid;
        la_bank   <= nxt_bank;
        la_row    <= nxt_row;
      end
      if (nx_cmd == CMD_RD || nx_cmd == CMD_WR) ccd_c <= CNT_W'(T_CCD - 1);
      else if (ccd_c != '0)                     ccd_c <= ccd_c - 1'b1;
      cmd_code <= nx_cmd;
      cmd_bank <= (nx_cmd == CMD_NOP) ? '0 : cur_bank;
      case (nx_cmd)
        CMD_ACT:        cmd_addr <= ADDR_W'(cur_row);
        CMD_RD, CMD_WR: cmd_addr <= ADDR_W'(cur_col);
        default:        cmd_addr <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dseq_chk.sv
module dseq_chk #(
  parameter int BANKS  = 8,
  parameter int T_RP   = 6,
  parameter int T_RCD  = 6,
  localparam int BANK_W = $clog2(BANKS)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        cmd_code,
  input logic [BANK_W-1:0] cmd_bank
);
  logic       sh_open   [BANKS];
  logic [7:0] since_pre [BANKS];
  logic [7:0] since_act [BANKS];

  always_ff @(posedge clk) begin
    for (int b = 0; b < BANKS; b++) begin
      if (rst) begin
        sh_open[b]   <= 1'b0;
        since_pre[b] <= 8'hff;
        since_act[b] <= 8'hff;
      end else begin
        if (since_pre[b] != 8'hff) since_pre[b] <= since_pre[b] + 8'd1;
        if (since_act[b] != 8'hff) since_act[b] <= since_act[b] + 8'd1;
        if (cmd_bank == BANK_W'(b) && cmd_code == 3'd1) begin
          sh_open[b]   <= 1'b1;
          since_act[b] <= 8'd1;
        end
        if (cmd_bank == BANK_W'(b) && cmd_code == 3'd4) begin
          sh_open[b]   <= 1'b0;
          since_pre[b] <= 8'd1;
        end
      end
    end
  end

  a_r1_nop_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cmd_code == 3'd0 && req_ready));
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  a_r12_code_legal: assert property (@(posedge clk) disable iff (rst)
    cmd_code <= 3'd4);
  a_r3_act_closed: assert property (@(posedge clk) disable iff (rst)
    cmd_code == 3'd1 |-> !sh_open[cmd_bank]);
  a_r5_pre_open: assert property (@(posedge clk) disable iff (rst)
    cmd_code == 3'd4 |-> sh_open[cmd_bank]);
  a_r6_trp_window: assert property (@(posedge clk) disable iff (rst)
    cmd_code == 3'd1 |-> since_pre[cmd_bank] >= 8'(T_RP));
  a_r7_trcd_window: assert property (@(posedge clk) disable iff (rst)
    (cmd_code == 3'd2 || cmd_code == 3'd3) |->
      (sh_open[cmd_bank] && since_act[cmd_bank] >= 8'(T_RCD)));
endmodule

bind dseq_top dseq_chk #(.BANKS(BANKS), .T_RP(T_RP), .T_RCD(T_RCD)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .cmd_code(cmd_code), .cmd_bank(cmd_bank)
);

// File: tb/dseq_top_tb_top.sv
module dseq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8, ROW_W = 14, COL_W = 10;
  localparam int T_RP = 6, T_RCD = 6, T_WL = 5, T_BURST = 4, T_WR = 7;
  localparam int T_RTP = 4, T_CCD = 4;
  localparam int WR2PRE = T_WL + T_BURST + T_WR;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_write = 0, nxt_valid = 0;
  logic [2:0] req_bank = 0, nxt_bank = 0;
  logic [ROW_W-1:0] req_row = 0, nxt_row = 0;
  logic [COL_W-1:0] req_col = 0;
  logic req_ready;
  logic [2:0] cmd_code, cmd_bank;
  logic [13:0] cmd_addr;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dseq_top #(.BANKS(NB), .ROW_W(ROW_W), .COL_W(COL_W), .T_RP(T_RP),
    .T_RCD(T_RCD), .T_WL(T_WL), .T_BURST(T_BURST), .T_WR(T_WR),
    .T_RTP(T_RTP), .T_CCD(T_CCD)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: timing legality from observed commands
  bit mo_open [NB];
  int t_pre [NB], t_act [NB], t_wr [NB], t_rd [NB];
  int t_col = -1000;
  int g_code [16], g_bank [16], g_addr [16];
  int g_n = 0;

  initial for (int b = 0; b < NB; b++) begin
    mo_open[b] = 0; t_pre[b] = -1000; t_act[b] = -1000;
    t_wr[b] = -1000; t_rd[b] = -1000;
  end

  always @(negedge clk) begin
    cyc++;
    if (!rst && cmd_code != 3'd0) begin
      int b;
      b = int'(cmd_bank);
      if (g_n < 16) begin
        g_code[g_n] = int'(cmd_code); g_bank[g_n] = b; g_addr[g_n] = int'(cmd_addr);
      end
      g_n++;
      case (cmd_code)
        3'd1: begin
          chk(!mo_open[b], "R3 act on open bank", int'(mo_open[b]), 0);
          chk(cyc - t_pre[b] >= T_RP, "R6 pre-to-act gap", cyc - t_pre[b], T_RP);
          mo_open[b] = 1; t_act[b] = cyc;
        end
        3'd2, 3'd3: begin
          chk(mo_open[b], "R7 column on closed bank", int'(mo_open[b]), 1);
          chk(cyc - t_act[b] >= T_RCD, "R7 act-to-col gap", cyc - t_act[b], T_RCD);
          chk(cyc - t_col >= T_CCD, "R9 col-to-col gap", cyc - t_col, T_CCD);
          t_col = cyc;
          if (cmd_code == 3'd3) t_wr[b] = cyc; else t_rd[b] = cyc;
        end
        3'd4: begin
          chk(mo_open[b], "R5 pre on closed bank", int'(mo_open[b]), 1);
          chk(cyc - t_wr[b] >= WR2PRE, "R8 wr-to-pre gap", cyc - t_wr[b], WR2PRE);
          chk(cyc - t_rd[b] >= T_RTP, "R8 rd-to-pre gap", cyc - t_rd[b], T_RTP);
          mo_open[b] = 0; t_pre[b] = cyc;
        end
        default: chk(0, "R12 illegal code", int'(cmd_code), 0);
      endcase
    end
  end

  // expected-sequence model
  bit m_open [NB];
  int m_row [NB];
  initial for (int b = 0; b < NB; b++) begin m_open[b] = 0; m_row[b] = 0; end

  task automatic run_req(input bit w, input int b, input int row, input int col,
                         input bit nv, input int nb, input int nrow, input string tag);
    int e_code [4], e_bank [4], e_addr [4];
    int n = 0;
    if (m_open[b] && m_row[b] != row) begin
      e_code[n] = 4; e_bank[n] = b; e_addr[n] = 0; n++; m_open[b] = 0;
    end
    if (!m_open[b]) begin
      e_code[n] = 1; e_bank[n] = b; e_addr[n] = row; n++;
      m_open[b] = 1; m_row[b] = row;
    end
    e_code[n] = w ? 3 : 2; e_bank[n] = b; e_addr[n] = col; n++;
    if (nv && nb == b && nrow != row) begin
      e_code[n] = 4; e_bank[n] = b; e_addr[n] = 0; n++; m_open[b] = 0;
    end
    g_n = 0;
    req_valid = 1; req_write = w; req_bank = 3'(b); req_row = 14'(row);
    req_col = 10'(col); nxt_valid = nv; nxt_bank = 3'(nb); nxt_row = 14'(nrow);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, {tag, " R2 ready low after accept"}, int'(req_ready), 0);
    while (!req_ready) @(negedge clk);
    #1;
    chk(g_n == n, {tag, " command count"}, g_n, n);
    for (int i = 0; i < n && i < g_n; i++) begin
      chk(g_code[i] == e_code[i], {tag, " R12 command code"}, g_code[i], e_code[i]);
      chk(g_bank[i] == e_bank[i], {tag, " R12 command bank"}, g_bank[i], e_bank[i]);
      chk(g_addr[i] == e_addr[i], {tag, " R12 command addr"}, g_addr[i], e_addr[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int pw, pb, pr, pc;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    #1;
    chk(cmd_code == 3'd0, "R1 NOP after reset", int'(cmd_code), 0);
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);

    // R1/R3/R7: closed bank, exact act-to-write gap
    run_req(1, 0, 5, 17, 0, 0, 0, "R3 first write");
    chk(t_wr[0] - t_act[0] == T_RCD, "R7 exact act-to-wr", t_wr[0] - t_act[0], T_RCD);
    // R4: hit, R9 spacing
    run_req(1, 0, 5, 18, 0, 0, 0, "R4 row hit");
    // R11: other bank while bank 0 open, then hit bank 0 again
    run_req(0, 3, 9, 2, 0, 0, 0, "R11 other bank");
    run_req(0, 0, 5, 3, 0, 0, 0, "R11 hit after other bank");
    // R5: unplanned miss on bank 3
    run_req(0, 3, 10, 4, 0, 0, 0, "R5 row miss");
    // R10: lookahead close after write, exact gap
    run_req(1, 1, 2, 6, 1, 1, 3, "R10 early close");
    chk(t_pre[1] - t_wr[1] == WR2PRE, "R8 exact wr-to-pre", t_pre[1] - t_wr[1], WR2PRE);
    run_req(0, 1, 3, 7, 1, 2, 0, "R10 after early close");
    // R10: lookahead same row / other bank leaves open
    run_req(1, 2, 4, 1, 1, 2, 4, "R10 same row ahead");
    run_req(1, 2, 4, 2, 1, 5, 1, "R10 other bank ahead");

    // constrained random, lookahead = actual next request
    pw = $urandom % 2; pb = $urandom % 3; pr = $urandom % 3; pc = $urandom % 1024;
    for (int k = 0; k < 400; k++) begin
      int cw, cb, cr, cc;
      bit nv;
      cw = pw; cb = pb; cr = pr; cc = pc;
      pw = $urandom % 2;
      pb = ($urandom % 4 == 0) ? ($urandom % NB) : ($urandom % 3);
      pr = $urandom % 3; pc = $urandom % 1024;
      nv = ($urandom % 4) != 0;
      run_req(cw[0], cb, cr, cc, nv, pb, pr, "random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule